// File: doc/BRIEF.md
# Instruction Cache Line State Controller

This block keeps the per-line state of a four-way set-associative, read-only instruction cache. Each line is either invalid or valid. The processor sends read requests over a request/ready port. A hit is answered from the local data array one cycle after the request is accepted. A miss starts a four-beat burst fill from a simple memory read port. The burst starts with the word the processor asked for, and that word is passed back as soon as it arrives. Processor writes are illegal: they are answered with an error flag and never reach the arrays.

A separate command port acts on one line, named by set and way. The invalidate command and the dropping push command both clear a valid line. The keeping push command leaves the line valid. None of the commands does anything to a line that is already invalid. On a fill, the lowest-numbered invalid way of the set is used. When all four ways of the set are valid, one global rotating pointer picks the victim. While a fill is in progress, both the processor port and the command port are held off.

Top module: `icache_line_ctrl`

## Requirements
- R1: After reset every line is invalid and the rotating pointer is 0. `req_ready` and `cmd_ready` are high, and `rsp_valid` and `mem_req` are low.
- R2: Address fields are: tag = addr[31:10], set = addr[9:4], word = addr[3:2]. When a read misses on a set that has an invalid way, `mem_req` is high for exactly one cycle, the cycle after acceptance, with `mem_addr` equal to the byte address of the requested word (addr[1:0] cleared). The first beat's data appears on `rsp_data` with `rsp_valid` in the cycle after that beat, and the line is valid once the fourth beat is taken.
- R3: A read hit returns the stored word with `rsp_valid` high and `rsp_err` low in the cycle after acceptance. It issues no `mem_req` and leaves line state unchanged.
- R4: A write request (`req_write`=1) is answered with `rsp_valid` and `rsp_err` high in the cycle after acceptance. It issues no `mem_req` and leaves tag and data contents unchanged.
- R5: `cmd_op`=2'b01 (invalidate) clears the valid bit of the named line. It has no effect on a line that is already invalid.
- R6: `cmd_op`=2'b10 (push, drop) clears the valid bit of the named line. `cmd_op`=2'b11 (push, keep) leaves it valid. `cmd_op`=2'b00 does nothing.
- R7: A fill goes into the lowest-numbered invalid way of the indexed set.
- R8: When all four ways of the set are valid, the fill replaces the way named by the rotating pointer. The pointer advances by one (mod 4) after each such replacing fill and after no other event.
- R9: From the acceptance of a missing read until the last beat is taken, `req_ready` and `cmd_ready` are low.
- R10: Beat k of a fill carries word (c+k) mod 4 of the line, where c is the requested word. Each beat is stored at that word position.
- R11: While idle, a command has priority: `req_ready` is low whenever `cmd_valid` is high, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write (illegal) |
| req_addr | input | 32 | Request byte address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Response word or error present |
| rsp_data | output | 32 | Response word |
| rsp_err | output | 1 | Response is an illegal-write error |
| cmd_valid | input | 1 | Line command present |
| cmd_op | input | 2 | 00 none, 01 invalidate, 10 push-drop, 11 push-keep |
| cmd_index | input | 6 | Set addressed by the command |
| cmd_way | input | 2 | Way addressed by the command |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| mem_req | output | 1 | One-cycle line fill request |
| mem_addr | output | 32 | Byte address of the first (requested) word of the burst |
| mem_rvalid | input | 1 | Fill beat present |
| mem_rdata | input | 32 | Fill beat data |

## Verification
On every cycle, the assertions check these behaviours:
- the set never hits in more than one way;
- a write always produces an error response and never a fill request;
- both ports are closed while a fill request is out;
- a completed fill leaves its line valid;
- a fill never lands on a valid way while an invalid one exists;
- the rotating pointer moves only on a replacing fill.

Only the bench scenarios can show the effects that depend on history. These are the wrapped burst placing words correctly, the exact order of victims under the rotating pointer, the difference between the two push commands, and that a rejected write leaves the old data readable.

// File: rtl/icache_lc_pkg.sv
package icache_lc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } lc_state_e;

    localparam logic [1:0] OP_NONE      = 2'b00;
    localparam logic [1:0] OP_INVAL     = 2'b01;
    localparam logic [1:0] OP_PUSH_DROP = 2'b10;
    localparam logic [1:0] OP_PUSH_KEEP = 2'b11;

endpackage

// File: rtl/icache_hit_detect.sv
module icache_hit_detect #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] hit_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = set_valid[g] && (set_tags[g] == look_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    // R3: a tag may live in at most one way of a set
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/icache_victim_pick.sv
module icache_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  set_valid,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic             all_valid,
    output logic [WAY_W-1:0] victim
);
    assign all_valid = &set_valid;

    always_comb begin
        victim = rr_ptr;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!set_valid[i]) victim = WAY_W'(i);
        end
    end

endmodule

// File: rtl/icache_line_ctrl.sv
module icache_line_ctrl
    import icache_lc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4,
    localparam int BYTE_OFF  = $clog2(DATA_W / 8),
    localparam int WORD_BITS = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int TAG_W     = ADDR_W - IDX_W - WORD_BITS - BYTE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [WAY_W-1:0]  cmd_way,
    output logic              cmd_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        lc_state_e                     state;
        logic [IDX_W-1:0]              idx;
        logic [TAG_W-1:0]              tag;
        logic [WORD_BITS-1:0]          crit;
        logic [WORD_BITS-1:0]          cnt;
        logic [WAY_W-1:0]              way;
        logic                          repl;
        logic [WAY_W-1:0]              rr;
        logic                          rsp_valid;
        logic [DATA_W-1:0]             rsp_data;
        logic                          rsp_err;
        logic [SETS-1:0][WAYS-1:0]     valid;
    } lc_state_t;

    lc_state_t st_d, st_q;

    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [DATA_W-1:0] data_mem [SETS][WAYS][LINE_WORDS];

    // request address fields
    logic [TAG_W-1:0]     req_tag;
    logic [IDX_W-1:0]     req_idx;
    logic [WORD_BITS-1:0] req_word;
    logic                 unused_byte_bits;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[BYTE_OFF+WORD_BITS +: IDX_W];
    assign req_word = req_addr[BYTE_OFF +: WORD_BITS];
    assign unused_byte_bits = ^req_addr[BYTE_OFF-1:0];

    // lookup of the indexed set
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic                       all_valid;
    logic [WAY_W-1:0]           victim;

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_mem[req_idx][w];
        set_valid = st_q.valid[req_idx];
    end

    icache_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (set_valid),
        .set_tags  (set_tags),
        .look_tag  (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    icache_victim_pick #(.WAYS(WAYS)) u_victim (
        .set_valid (set_valid),
        .rr_ptr    (st_q.rr),
        .all_valid (all_valid),
        .victim    (victim)
    );

    logic                 accept_req;
    logic                 accept_cmd;
    logic                 beat_take;
    logic                 last_beat;
    logic [WORD_BITS-1:0] beat_word;

    assign req_ready  = (st_q.state == ST_IDLE) && !cmd_valid;
    assign cmd_ready  = (st_q.state == ST_IDLE);
    assign accept_req = req_valid && req_ready;
    assign accept_cmd = cmd_valid && cmd_ready;
    assign beat_take  = (st_q.state == ST_FILL) && mem_rvalid;
    assign last_beat  = beat_take && (st_q.cnt == WORD_BITS'(LINE_WORDS - 1));
    assign beat_word  = st_q.crit + st_q.cnt;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (accept_cmd) begin
                    if (cmd_op == OP_INVAL || cmd_op == OP_PUSH_DROP)
                        st_d.valid[cmd_index][cmd_way] = 1'b0;
                end else if (accept_req) begin
                    if (req_write) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_err   = 1'b1;
                    end else if (hit) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_data  = data_mem[req_idx][hit_way][req_word];
                    end else begin
                        st_d.state = ST_REQ;
                        st_d.idx   = req_idx;
                        st_d.tag   = req_tag;
                        st_d.crit  = req_word;
                        st_d.cnt   = '0;
                        st_d.way   = victim;
                        st_d.repl  = all_valid;
                    end
                end
            end
            ST_REQ: st_d.state = ST_FILL;
            ST_FILL: begin
                if (beat_take) begin
                    st_d.cnt = st_q.cnt + WORD_BITS'(1);
                    if (st_q.cnt == '0) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_data  = mem_rdata;
                    end
                    if (last_beat) begin
                        st_d.valid[st_q.idx][st_q.way] = 1'b1;
                        st_d.state = ST_IDLE;
                        if (st_q.repl) st_d.rr = st_q.rr + WAY_W'(1);
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (beat_take) begin
            data_mem[st_q.idx][st_q.way][beat_word] <= mem_rdata;
            if (st_q.cnt == '0) tag_mem[st_q.idx][st_q.way] <= st_q.tag;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_err   = st_q.rsp_err;
    assign mem_req   = (st_q.state == ST_REQ);
    assign mem_addr  = {st_q.tag, st_q.idx, st_q.crit, {BYTE_OFF{1'b0}}};

    // R4: a write is always answered with an error
    p_write_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_req && req_write |=> rsp_valid && rsp_err);

    // R4: a write never starts a fill
    p_write_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_req && req_write |=> !mem_req);

    // R9: both ports closed while a fill request is out
    p_fill_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready && !cmd_ready);

    // R2: a completed fill leaves its line valid
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> st_q.valid[st_q.idx][st_q.way]);

    // R7: the fill target is invalid whenever the set had a free way
    p_free_way_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_req && !req_write && !hit && !all_valid
        |=> !st_q.valid[st_q.idx][st_q.way] && !st_q.repl);

    // R8: the rotating pointer moves only on a replacing fill
    p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_beat && st_q.repl) |=> $stable(st_q.rr));

endmodule

// File: tb/icache_line_ctrl_bench.sv
module icache_line_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_addr;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [5:0]  cmd_index;
    logic [1:0]  cmd_way;
    logic        cmd_ready, mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    icache_line_ctrl u_icache_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_index(cmd_index), .cmd_way(cmd_way), .cmd_ready(cmd_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // memory contents: a function of line address and word position
    function automatic logic [31:0] mword(input logic [31:0] line, input logic [1:0] w);
        return (line ^ (32'h0101_0107 * (32'(w) + 1))) + 32'h0000_1111;
    endfunction

    task automatic check(input logic ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one processor access, with the memory side served by the bench
    task automatic access(input logic wr, input logic [31:0] a,
                          output logic seen, output int rcyc, output logic [31:0] rdat,
                          output logic rerr, output logic mseen,
                          output logic [31:0] maddr, output logic busy_ok);
        int beat;
        logic run;
        seen = 0; rcyc = -1; rdat = 0; rerr = 0; mseen = 0; maddr = 0;
        busy_ok = 1; beat = 0; run = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        for (int c = 0; c < 10; c++) begin
            if (rsp_valid && !seen) begin
                seen = 1; rcyc = c; rdat = rsp_data; rerr = rsp_err;
            end
            mem_rvalid = 0;
            if (run && beat < 4) begin
                busy_ok &= !req_ready && !cmd_ready;
                mem_rvalid = 1;
                mem_rdata  = mword({maddr[31:4], 4'h0}, maddr[3:2] + beat[1:0]);
                beat++;
            end
            if (mem_req) begin
                mseen = 1; maddr = mem_addr; run = 1;
            end
            @(negedge clk);
        end
        mem_rvalid = 0;
    endtask

    // read or write with the expected outcome checked
    task automatic run_access(input logic wr, input logic [31:0] a,
                              input logic exp_miss, input string rq);
        logic seen, rerr, mseen, busy_ok;
        int rcyc;
        logic [31:0] rdat, maddr, expd;
        access(wr, a, seen, rcyc, rdat, rerr, mseen, maddr, busy_ok);
        expd = mword({a[31:4], 4'h0}, a[3:2]);
        if (wr) begin
            check(seen && rerr && rcyc == 0, {rq, " R4 error response"}, 32'(rcyc), 0);
            check(!mseen, {rq, " R4 no fill"}, 32'(mseen), 0);
        end else if (exp_miss) begin
            check(mseen && maddr == {a[31:2], 2'b00}, {rq, " R2 R10 fill address"},
                  maddr, {a[31:2], 2'b00});
            check(seen && !rerr && rcyc == 2 && rdat == expd,
                  {rq, " R2 critical word forward"}, rdat, expd);
            check(busy_ok, {rq, " R9 ports closed during fill"}, 32'(busy_ok), 1);
        end else begin
            check(!mseen, {rq, " R3 hit without fill"}, 32'(mseen), 0);
            check(seen && !rerr && rcyc == 0 && rdat == expd,
                  {rq, " R3 hit data"}, rdat, expd);
        end
    endtask

    task automatic line_cmd(input logic [1:0] op, input logic [5:0] idx,
                            input logic [1:0] way);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_index = idx; cmd_way = way;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // {write, expect miss, 2'b0, address}
    localparam int NVEC = 8;
    localparam logic [35:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 2'b00, 32'h0000_1004},   // R1 R2 first access misses, set 0 way 0
        {1'b0, 1'b0, 2'b00, 32'h0000_1008},   // R3 R10 other word of wrapped fill
        {1'b0, 1'b1, 2'b00, 32'h0000_200C},   // R7 set 0 fills way 1
        {1'b0, 1'b0, 2'b00, 32'h0000_1000},   // R3
        {1'b1, 1'b0, 2'b00, 32'h0000_1000},   // R4 write rejected
        {1'b0, 1'b0, 2'b00, 32'h0000_1000},   // R4 old data still readable
        {1'b0, 1'b1, 2'b00, 32'h0000_3010},   // R2 set 1
        {1'b0, 1'b0, 2'b00, 32'h0000_301C}    // R10 last word after wrap
    };

    function automatic logic [31:0] rr_addr(input int k);
        return (32'(k) << 10) | 32'h0000_0050;
    endfunction

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0;
        cmd_valid = 0; cmd_op = 0; cmd_index = 0; cmd_way = 0;
        mem_rvalid = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && cmd_ready && !rsp_valid && !mem_req, "R1 reset outputs",
              {28'h0, req_ready, cmd_ready, rsp_valid, mem_req}, 32'hC);

        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i][35], VECS[i][31:0], VECS[i][34], $sformatf("vec%0d", i));
        end

        // R5 invalidate of an invalid way changes nothing
        line_cmd(2'b01, 6'd0, 2'd2);
        run_access(0, 32'h0000_1000, 0, "R5 inval invalid way");
        run_access(0, 32'h0000_2000, 0, "R5 inval invalid way");
        // R5 invalidate of a valid way
        line_cmd(2'b01, 6'd0, 2'd0);
        run_access(0, 32'h0000_1004, 1, "R5 inval valid way");
        run_access(0, 32'h0000_2004, 0, "R5 neighbour kept");
        // R6 push variants
        line_cmd(2'b11, 6'd0, 2'd1);
        run_access(0, 32'h0000_2008, 0, "R6 push keep");
        line_cmd(2'b00, 6'd0, 2'd1);
        run_access(0, 32'h0000_2008, 0, "R6 no-op command");
        line_cmd(2'b10, 6'd0, 2'd1);
        run_access(0, 32'h0000_2008, 1, "R6 push drop");
        // R7 refill landed in way 1, the lowest invalid way
        line_cmd(2'b01, 6'd0, 2'd1);
        run_access(0, 32'h0000_2000, 1, "R7 refill way");
        run_access(0, 32'h0000_1000, 0, "R7 way 0 untouched");

        // R11 command priority
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b00; cmd_index = 0; cmd_way = 0;
        req_valid = 1; req_write = 0; req_addr = 32'h0000_1000;
        #1;
        check(!req_ready && cmd_ready, "R11 command priority",
              {30'h0, req_ready, cmd_ready}, 32'h1);
        @(negedge clk);
        cmd_valid = 0; req_valid = 0;
        check(!rsp_valid, "R11 request held off", 32'(rsp_valid), 0);

        // R8 rotating victim on set 5
        for (int k = 1; k <= 4; k++) run_access(0, rr_addr(k), 1, "R7 fill set 5");
        run_access(0, rr_addr(5), 1, "R8 replace way 0");
        for (int k = 2; k <= 4; k++) run_access(0, rr_addr(k), 0, "R8 after ptr 0");
        run_access(0, rr_addr(6), 1, "R8 replace way 1");
        for (int k = 3; k <= 5; k++) run_access(0, rr_addr(k), 0, "R8 after ptr 1");
        run_access(0, rr_addr(1), 1, "R8 replace way 2");
        for (int k = 4; k <= 6; k++) run_access(0, rr_addr(k), 0, "R8 after ptr 2");
        run_access(0, rr_addr(2), 1, "R8 replace way 3");
        run_access(0, rr_addr(5), 0, "R8 after ptr 3");
        run_access(0, rr_addr(6), 0, "R8 after ptr 3");
        run_access(0, rr_addr(1), 0, "R8 after ptr 3");
        run_access(0, rr_addr(3), 1, "R8 evicted earlier");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule